// File: doc/BRIEF.md
# DRAM Refresh Sequencer (CAS-before-RAS)

This block keeps an asynchronous DRAM refreshed by issuing CAS-before-RAS refresh cycles. The memory supplies the row address from its own internal counter, so the block never drives an address. A free-running interval timer raises a refresh request. The request goes to the access sequencer that owns the memory pins through a request/grant handshake. The block drives RAS, CAS, write-enable and a pin-drive enable only after the grant has been seen and while its request is held.

After reset the block must first run a burst of `INIT_REFRESH` refresh cycles (eight or more) before the memory may be used. `ready` stays low until that burst is done. After that, periodic refreshes are counted. A sticky flag records any case where a second timer interval ran out while the previous request was still waiting for a grant.

All timing is in clock cycles: `T_CSR` is the CAS lead ahead of RAS, `T_CHR` is the CAS hold after RAS falls, and `T_RAS` is the RAS low width. The precharge length and the refresh interval are run-time inputs.

Top module: `dram_cbr_refresh`

## Requirements
- R1: After reset, `ready`=0, `ovf`=0, `ref_cnt`=0, `drv_en`=0, `ras_n`=`cas_n`=`we_n`=1, and `ref_req`=1, because the initial burst is owed.
- R2: The block never sets `drv_en` without a grant. A refresh starts on the first clock edge at which `ref_req` and `ref_gnt` are both high while the block is idle, and `drv_en` is high from the next cycle on.
- R3: Each refresh begins with `T_CSR` cycles of `cas_n`=0, `ras_n`=1 and `we_n`=1. CAS therefore falls before RAS.
- R4: `ras_n` then stays 0 for exactly `T_RAS` cycles. `cas_n` stays 0 for the first `T_CHR` of those cycles and is 1 for the rest. `we_n` stays 1 throughout.
- R5: After RAS rises, `ras_n`=`cas_n`=1 with `drv_en`=1 for `cfg_precharge`+1 cycles. `drv_en` then drops for at least one idle cycle before any new refresh.
- R6: `ref_req` stays high through the first `INIT_REFRESH` refreshes. `ready` rises in the cycle after the last precharge cycle of that burst.
- R7: Once `ready` rises, it stays high until reset.
- R8: The timer starts when `ready` rises and marks a refresh due every `cfg_interval` cycles. `ref_req` is seen high `cfg_interval` cycles after `ready` first rises, and again at each further multiple. Once raised, it stays high until the refresh is granted.
- R9: `ref_cnt` counts completed refreshes after the initial burst. It goes up by one at the end of each precharge, and initial-burst refreshes do not count.
- R10: If a timer interval ends while the previous request is still pending and not starting, `ovf` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | IW | Refresh period in cycles (at least 2) |
| cfg_precharge | input | PW | Extra RAS-high cycles after each refresh |
| ref_gnt | input | 1 | Grant of the memory pins from the access sequencer |
| ref_req | output | 1 | Refresh wanted or in progress |
| drv_en | output | 1 | Block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| ready | output | 1 | Initial refresh burst done |
| ref_cnt | output | CW | Periodic refreshes completed |
| ovf | output | 1 | A refresh interval was missed (sticky) |

## Verification
A wrong phase counter or state shows at once in the per-cycle strobe pattern. A lead, hold or precharge that is one cycle short or long is caught in the very cycle it differs. A wrong burst count shows as `ready` rising one refresh early or late, and a slipped timer shows as `ref_req` rising away from an exact multiple of `cfg_interval` cycles after `ready`. A lost pending request or a missed overflow shows as `ref_req` dropping, or `ovf` staying low, within one interval.

// File: rtl/dram_cbr_refresh.sv
module dram_cbr_refresh #(
  parameter int INIT_REFRESH = 8,
  parameter int T_CSR = 2,
  parameter int T_CHR = 2,
  parameter int T_RAS = 11,
  parameter int IW = 16,
  parameter int PW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cfg_interval,
  input  logic [PW-1:0] cfg_precharge,
  input  logic          ref_gnt,
  output logic          ref_req,
  output logic          drv_en,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          ready,
  output logic [CW-1:0] ref_cnt,
  output logic          ovf
);

  localparam int PHW = PW + 1;
  localparam int INW = $clog2(INIT_REFRESH + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_STROBE, S_PRE} st_t;

  st_t            st;
  logic [PHW-1:0] ph;
  logic [INW-1:0] init_left;
  logic [IW-1:0]  tmr;
  logic           pending;

  wire want  = pending || !ready;
  wire start = (st == S_IDLE) && want && ref_gnt;
  wire tick  = ready && (tmr == cfg_interval - IW'(1));
  wire last  = (st == S_PRE) && (ph == {1'b0, cfg_precharge});

  assign ref_req = (st != S_IDLE) || want;
  assign drv_en  = (st != S_IDLE);
  assign ras_n   = (st != S_STROBE);
  assign cas_n   = !((st == S_LEAD) || ((st == S_STROBE) && (ph < PHW'(T_CHR))));
  assign we_n    = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= '0;
      init_left <= INW'(INIT_REFRESH);
      ready     <= 1'b0;
      tmr       <= '0;
      pending   <= 1'b0;
      ovf       <= 1'b0;
      ref_cnt   <= '0;
    end else begin
      case (st)
        S_IDLE:   if (start) begin st <= S_LEAD; ph <= '0; end
        S_LEAD:   if (ph == PHW'(T_CSR - 1)) begin st <= S_STROBE; ph <= '0; end
                  else ph <= ph + 1'b1;
        S_STROBE: if (ph == PHW'(T_RAS - 1)) begin st <= S_PRE; ph <= '0; end
                  else ph <= ph + 1'b1;
        S_PRE:    if (last) begin st <= S_IDLE; ph <= '0; end
                  else ph <= ph + 1'b1;
        default:  st <= S_IDLE;
      endcase
      if (last) begin
        if (init_left != '0) begin
          init_left <= init_left - 1'b1;
          if (init_left == INW'(1)) ready <= 1'b1;
        end else begin
          ref_cnt <= ref_cnt + 1'b1;
        end
      end
      if (ready) tmr <= tick ? '0 : tmr + 1'b1;
      pending <= tick || (pending && !start);
      if (tick && pending && !start) ovf <= 1'b1;
    end
  end

  logic [PHW-1:0] ras_low_len;
  always_ff @(posedge clk) begin
    if (!rst_n) ras_low_len <= '0;
    else if (!ras_n) ras_low_len <= ras_low_len + 1'b1;
    else ras_low_len <= '0;
  end

  p_grant_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(ref_gnt && ref_req));
  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> ref_req);
  p_cas_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  p_cas_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !cas_n);
  p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_low_len == PHW'(T_RAS)));
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cnt != $past(ref_cnt)) |-> (ref_cnt == $past(ref_cnt) + 1'b1) && $fell(drv_en));

endmodule

// File: tb/sim_dram_cbr_refresh.sv
module sim_dram_cbr_refresh;
  localparam int T_CSR = 2, T_CHR = 2, T_RAS = 11, INIT = 8, IVL = 40;

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic [15:0] cfg_interval = 16'(IVL);
  logic [7:0]  cfg_precharge = 0;
  logic ref_req, drv_en, ras_n, cas_n, we_n, ready, ovf;
  logic [15:0] ref_cnt;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  dram_cbr_refresh u0 (.clk, .rst_n, .cfg_interval, .cfg_precharge, .ref_gnt,
    .ref_req, .drv_en, .ras_n, .cas_n, .we_n, .ready, .ref_cnt, .ovf);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic pins(string tag, int d, int r, int c);
    check({tag, " drv_en"}, int'(drv_en), d);
    check({tag, " ras_n"}, int'(ras_n), r);
    check({tag, " cas_n"}, int'(cas_n), c);
    check({tag, " we_n"}, int'(we_n), 1);
  endtask

  task automatic run_one(int pre, int req_after);
    cfg_precharge = 8'(pre);
    ref_gnt = 1;
    for (int i = 0; i < T_CSR; i++) begin @(negedge clk); pins("R3 lead", 1, 1, 0); end
    for (int i = 0; i < T_RAS; i++) begin
      @(negedge clk); pins("R4 strobe", 1, 0, (i < T_CHR) ? 0 : 1);
    end
    for (int i = 0; i <= pre; i++) begin @(negedge clk); pins("R5 precharge", 1, 1, 1); end
    @(negedge clk);
    pins("R5 release", 0, 1, 1);
    check("R2 req after refresh", int'(ref_req), req_after);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    pins("R1 reset", 0, 1, 1);
    check("R1 ready", int'(ready), 0);
    check("R1 ovf", int'(ovf), 0);
    check("R1 ref_cnt", int'(ref_cnt), 0);
    check("R1 req", int'(ref_req), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R2 no drive without grant", int'(drv_en), 0);
    end
    for (int k = 0; k < INIT; k++) begin
      check("R6 ready low in burst", int'(ready), 0);
      run_one(k % 4, (k < INIT - 1) ? 1 : 0);
    end
    c0 = cyc;
    ref_gnt = 0;
    check("R6 ready after burst", int'(ready), 1);
    check("R9 burst not counted", int'(ref_cnt), 0);
    for (int j = 1; j <= 4; j++) begin
      while (!ref_req && cyc - c0 < 10 * IVL) @(negedge clk);
      check("R8 request period", cyc - c0, j * IVL);
      run_one(j - 1, 0);
      ref_gnt = 0;
      check("R9 ref_cnt", int'(ref_cnt), j);
      check("R7 ready sticky", int'(ready), 1);
    end
    while (!ref_req && cyc - c0 < 10 * IVL) @(negedge clk);
    check("R8 request period", cyc - c0, 5 * IVL);
    while (cyc - c0 < 6 * IVL - 1) @(negedge clk);
    check("R10 no ovf yet", int'(ovf), 0);
    check("R8 req held", int'(ref_req), 1);
    check("R2 idle without grant", int'(drv_en), 0);
    @(negedge clk);
    check("R10 ovf set", int'(ovf), 1);
    check("R8 req held", int'(ref_req), 1);
    run_one(2, 0);
    ref_gnt = 0;
    check("R9 ref_cnt", int'(ref_cnt), 5);
    check("R10 ovf sticky", int'(ovf), 1);
    check("R7 ready sticky", int'(ready), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule